// File: doc/BRIEF.md
# Serial EEPROM Slave Command Engine

This block is the slave side of a serial EEPROM that speaks SPI mode 0 over a 1024-byte array. A host lowers chip select, shifts in a one-byte command, and for array access a two-byte address. It then either clocks data out or shifts data in. The SPI pins are oversampled in the system clock domain. The serial clock therefore has to run well below the system clock: each SCK phase must last at least four system clocks.

A read streams bytes out from the given address onwards and never stops on its own. The address wraps from the top of the array back to zero. Write data goes into a one-page (32-byte) buffer. The in-page offset wraps, and only the offsets actually received are marked. The page is committed to the array only when chip select ends the command cleanly. A timed busy window then follows, and the marked bytes are copied into the array during it. An enable latch, a two-bit protection level and a write-permit input from an outside protection controller decide whether a page commit or a status write takes effect.

Top module: `eep_spi_engine`

## Requirements
- R1: Command 0x05 returns the status byte repeatedly until chip select rises. The status byte is bit 0 busy, bit 1 enable latch, bits 3:2 protection level, and bits 7:4 zero. Command 0x06 sets the enable latch and command 0x04 clears it. Both take effect at the end of the command byte.
- R2: Command 0x03 is followed by a 16-bit address, MSB first, and only its low 10 bits select a byte. The addressed byte and then consecutive bytes are shifted out MSB first. SPI_MOSI is sampled on rising SCK and SPI_MISO changes after falling SCK.
- R3: A read that passes address 0x3FF continues at address 0x000.
- R4: Command 0x02 is followed by a 16-bit address and data bytes. Each byte lands at the current offset within the 32-byte page of that address, and the offset wraps from 31 to 0. A later byte for the same offset replaces an earlier one. Page bytes that were not received keep their array contents.
- R5: A page write is committed only if chip select rises on a byte boundary after at least one complete data byte. A write aborted mid-byte, or one with no data byte, changes nothing and does not raise busy.
- R6: A page write is rejected while the enable latch is clear. An accepted commit clears the enable latch. A rejected one leaves the latch as it was.
- R7: After a commit, busy is high for exactly WR_CYCLES system clocks. While busy is high, only command 0x05 is honoured: a read returns zeros and command 0x06 has no effect.
- R8: Protection level 0 protects nothing, level 1 protects 0x300–0x3FF, level 2 protects 0x200–0x3FF, and level 3 protects the whole array. A page write aimed at a protected page is rejected.
- R9: Command 0x01 followed by a byte loads bits 3:2 of that byte into the protection level. This happens at chip-select rise on a byte boundary, and only if the enable latch is set and wr_permit is high. An accepted status write clears the enable latch.
- R10: Any other command byte is ignored and leaves the status unchanged.
- R11: SPI_MISO is low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| wr_permit | input | 1 | High when the protection controller allows status writes |
| busy | output | 1 | High during the timed write cycle |

## Verification
On every cycle, the assertions check these things: the output stays quiet while deselected; the busy window only opens with the enable latch set and on an unprotected page, and it closes within its count; the enable latch stays clear throughout busy; the protection level changes only when the latch and the permit allowed it; and every buffered byte is marked. Only the bench's scenarios can show that the array contents are right. That covers page-offset wrapping with later bytes winning, untouched bytes surviving, array-wide read wrap, discarded aborted writes, each protection level's boundary, and the exact busy length.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam logic [7:0] OP_SETEN   = 8'h06;
  localparam logic [7:0] OP_CLREN   = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_WRITE   = 8'h02;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADH, PH_ADL, PH_RD, PH_WR, PH_SRD, PH_SWR, PH_IGN
  } phase_e;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [7:0]        rd_data,
  output logic              rd_valid
);
  localparam int NB = 1 << PAGE_W;

  logic [7:0]    data_q [NB];
  logic [NB-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (clr)     mask_d = '0;
    else if (wr) mask_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  always_ff @(posedge clk) begin
    if (wr) data_q[wr_idx] <= wr_data;
  end

  assign rd_data  = data_q[rd_idx];
  assign rd_valid = mask_q[rd_idx];

  assert_mark_after_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr) |=> mask_q[$past(wr_idx)]);
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eep_spi_engine.sv
module eep_spi_engine
  import eep_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  input  logic wr_permit,
  output logic busy
);
  localparam int NB = 1 << PAGE_W;
  localparam int CW = $clog2(WR_CYCLES);
  localparam int PG = ADDR_W - PAGE_W;

  function automatic logic prot_hit(input logic [1:0] lvl, input logic [1:0] top);
    case (lvl)
      2'd0:    prot_hit = 1'b0;
      2'd1:    prot_hit = (top == 2'b11);
      2'd2:    prot_hit = top[1];
      default: prot_hit = 1'b1;
    endcase
  endfunction

  logic sck_s, cs_s, mosi_s, sck_d, cs_d;
  logic sck_rise, sck_fall, cs_rise;

  phase_e            phase_q, phase_d;
  logic [2:0]        bit_q, bit_d;
  logic [6:0]        shin_q, shin_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              wrm_q, wrm_d, got_q, got_d, wel_q, wel_d, busy_q, busy_d;
  logic [1:0]        swr_q, swr_d, bp_q, bp_d;
  logic [7:0]        out_q, out_d;
  logic [CW-1:0]     bcnt_q, bcnt_d;
  logic [PG-1:0]     cpage_q, cpage_d;

  logic [7:0] rx_byte, stat_byte, arr_rdata, pb_rdata;
  logic       pb_clr, pb_wr, pb_valid, arr_we, commit_ok, swr_ok;

  eep_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sck, spi_cs_n, spi_mosi}),
    .q({sck_s, cs_s, mosi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  assign sck_rise  = sck_s & ~sck_d & ~cs_s;
  assign sck_fall  = ~sck_s & sck_d & ~cs_s;
  assign cs_rise   = cs_s & ~cs_d;
  assign rx_byte   = {shin_q, mosi_s};
  assign stat_byte = {4'b0000, bp_q, wel_q, busy_q};

  assign commit_ok = (phase_q == PH_WR) && got_q && (bit_q == 3'd0) && wel_q &&
                     !prot_hit(bp_q, addr_q[ADDR_W-1:ADDR_W-2]);
  assign swr_ok    = (phase_q == PH_SWR) && got_q && (bit_q == 3'd0) && wel_q && wr_permit;

  eep_page_buf #(.PAGE_W(PAGE_W)) u_page (
    .clk(clk), .rst_n(rst_n), .clr(pb_clr), .wr(pb_wr),
    .wr_idx(addr_q[PAGE_W-1:0]), .wr_data(rx_byte),
    .rd_idx(bcnt_q[PAGE_W-1:0]), .rd_data(pb_rdata), .rd_valid(pb_valid)
  );

  assign arr_we = busy_q && (bcnt_q < CW'(NB)) && pb_valid;

  eep_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(arr_we), .waddr({cpage_q, bcnt_q[PAGE_W-1:0]}),
    .wdata(pb_rdata), .raddr(addr_q), .rdata(arr_rdata)
  );

  always_comb begin
    phase_d = phase_q;  bit_d  = bit_q;  shin_d = shin_q; addr_d  = addr_q;
    wrm_d   = wrm_q;    got_d  = got_q;  swr_d  = swr_q;  wel_d   = wel_q;
    bp_d    = bp_q;     out_d  = out_q;  busy_d = busy_q; bcnt_d  = bcnt_q;
    cpage_d = cpage_q;  pb_clr = 1'b0;   pb_wr  = 1'b0;

    if (busy_q) begin
      bcnt_d = bcnt_q + 1'b1;
      if (bcnt_q == CW'(WR_CYCLES - 1)) busy_d = 1'b0;
    end

    if (sck_rise) begin
      shin_d = rx_byte[6:0];
      bit_d  = bit_q + 1'b1;
      if (bit_q == 3'd7) begin
        case (phase_q)
          PH_OPC: begin
            phase_d = PH_IGN;
            if (rx_byte == OP_STAT_RD) phase_d = PH_SRD;
            else if (!busy_q) begin
              case (rx_byte)
                OP_SETEN:   wel_d = 1'b1;
                OP_CLREN:   wel_d = 1'b0;
                OP_STAT_WR: phase_d = PH_SWR;
                OP_READ:    begin phase_d = PH_ADH; wrm_d = 1'b0; end
                OP_WRITE:   begin phase_d = PH_ADH; wrm_d = 1'b1; pb_clr = 1'b1; end
                default:    ;
              endcase
            end
          end
          PH_ADH: begin
            addr_d[ADDR_W-1:8] = rx_byte[ADDR_W-9:0];
            phase_d = PH_ADL;
          end
          PH_ADL: begin
            addr_d[7:0] = rx_byte;
            phase_d = wrm_q ? PH_WR : PH_RD;
          end
          PH_RD:  addr_d = addr_q + 1'b1;
          PH_WR: begin
            pb_wr = 1'b1;
            got_d = 1'b1;
            addr_d[PAGE_W-1:0] = addr_q[PAGE_W-1:0] + 1'b1;
          end
          PH_SWR: begin
            swr_d = rx_byte[3:2];
            got_d = 1'b1;
          end
          default: ;
        endcase
      end
    end

    if (sck_fall) begin
      if (bit_q == 3'd0) begin
        case (phase_q)
          PH_RD:   out_d = arr_rdata;
          PH_SRD:  out_d = stat_byte;
          default: out_d = '0;
        endcase
      end else begin
        out_d = {out_q[6:0], 1'b0};
      end
    end

    if (cs_rise) begin
      if (commit_ok) begin
        busy_d  = 1'b1;
        bcnt_d  = '0;
        wel_d   = 1'b0;
        cpage_d = addr_q[ADDR_W-1:PAGE_W];
      end
      if (swr_ok) begin
        bp_d  = swr_q;
        wel_d = 1'b0;
      end
    end

    if (cs_s) begin
      phase_d = PH_OPC;
      bit_d   = '0;
      got_d   = 1'b0;
      out_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OPC; bit_q  <= '0;   shin_q <= '0;   addr_q  <= '0;
      wrm_q   <= 1'b0;   got_q  <= 1'b0; swr_q  <= '0;   wel_q   <= 1'b0;
      bp_q    <= '0;     out_q  <= '0;   busy_q <= 1'b0; bcnt_q  <= '0;
      cpage_q <= '0;
    end else begin
      phase_q <= phase_d; bit_q  <= bit_d;  shin_q <= shin_d; addr_q  <= addr_d;
      wrm_q   <= wrm_d;   got_q  <= got_d;  swr_q  <= swr_d;  wel_q   <= wel_d;
      bp_q    <= bp_d;    out_q  <= out_d;  busy_q <= busy_d; bcnt_q  <= bcnt_d;
      cpage_q <= cpage_d;
    end
  end

  assign spi_miso = out_q[7];
  assign busy     = busy_q;

  assert_miso_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s)) |-> !spi_miso);

  assert_commit_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> ($past(wel_q) && !wel_q));

  assert_commit_unprotected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !prot_hit(bp_q, cpage_q[PG-1:PG-2]));

  assert_busy_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (bcnt_q < CW'(WR_CYCLES)));

  assert_enable_frozen_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> !wel_q);

  assert_level_change_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp_q) |-> ($past(wel_q) && $past(wr_permit)));
endmodule

// File: tb/eep_spi_engine_tb.sv
module eep_spi_engine_tb;
  localparam int WRC = 1500;
  localparam int H   = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp = 1'b1;
  logic miso, busy;

  always #5 clk = ~clk;

  eep_spi_engine #(.ADDR_W(10), .PAGE_W(5), .WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .wr_permit(wp), .busy(busy)
  );

  int n_chk = 0, n_bad = 0, hi_cnt = 0;
  bit done = 1'b0;
  logic [7:0] em [1024];
  bit known [1024];
  logic ewel = 1'b0;
  logic [1:0] ebp = 2'd0;
  logic [7:0] dmy, s;

  always @(posedge clk) if (busy) hi_cnt <= hi_cnt + 1;

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k, input int seed);
    return 8'((k * 7 + seed * 13 + 1) & 255);
  endfunction

  function automatic bit prot(input logic [1:0] lvl, input logic [9:0] a);
    case (lvl)
      2'd0:    return 1'b0;
      2'd1:    return a[9:8] == 2'b11;
      2'd2:    return a[9];
      default: return 1'b1;
    endcase
  endfunction

  task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nb; i++) begin
      mosi = tx[7-i];
      repeat (H) @(negedge clk);
      rx[7-i] = miso;
      sck = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic cs_lo();
    @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] d;
    cs_lo(); xb(op, d); cs_hi();
    if (!busy && op == 8'h06) ewel = 1'b1;
    if (!busy && op == 8'h04) ewel = 1'b0;
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic [7:0] d;
    cs_lo(); xb(8'h05, d); xb(8'h00, v); cs_hi();
  endtask

  task automatic stat_chk(input string req);
    logic [7:0] v;
    rdsr(v);
    chk(v, {4'b0, ebp, ewel, 1'b0}, req, "status byte");
  endtask

  task automatic wait_ready();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    cs_lo(); xb(8'h01, d); xb(v, d); cs_hi();
    if (ewel && wp) begin ebp = v[3:2]; ewel = 1'b0; end
  endtask

  task automatic wr(input logic [15:0] a, input int n, input int seed, input string rej_req);
    logic [7:0] d;
    bit acc;
    int h0, base, off;
    acc = ewel && !prot(ebp, a[9:0]);
    h0 = hi_cnt;
    cs_lo(); xb(8'h02, d); xb(a[15:8], d); xb(a[7:0], d);
    for (int k = 0; k < n; k++) xb(pat(k, seed), d);
    cs_hi();
    if (acc) begin
      chk(busy, 1, "R5", "busy after commit");
      base = int'(a[9:0]) & ~31;
      off  = int'(a[4:0]);
      for (int k = 0; k < n; k++) begin
        em[base + ((off + k) % 32)]    = pat(k, seed);
        known[base + ((off + k) % 32)] = 1'b1;
      end
      ewel = 1'b0;
      wait_ready();
      chk(hi_cnt - h0, WRC, "R7", "busy length");
    end else begin
      chk(busy, 0, rej_req, "rejected write busy");
    end
  endtask

  task automatic rd(input logic [15:0] a, input int n, input string req);
    logic [7:0] d;
    int idx;
    cs_lo(); xb(8'h03, d); xb(a[15:8], d); xb(a[7:0], d);
    for (int k = 0; k < n; k++) begin
      xb(8'h00, d);
      idx = (int'(a[9:0]) + k) % 1024;
      if (known[idx]) chk(d, em[idx], req, $sformatf("read byte at %0h", idx));
    end
    cs_hi();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < 1024; i++) known[i] = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy, 0, "R7", "busy after reset");
    chk(miso, 0, "R11", "miso after reset");
    stat_chk("R1");

    // R1: enable latch set and clear
    op1(8'h06); stat_chk("R1");
    op1(8'h04); stat_chk("R1");

    // R4 fill pages, R6 latch clear after commit
    for (int p = 0; p < 6; p++) begin
      logic [15:0] pa;
      pa = (p < 4) ? 16'(p * 32) : 16'((26 + p) * 32);
      op1(8'h06);
      wr(pa, 32, p, "R6");
      stat_chk("R6");
    end
    chk(miso, 0, "R11", "miso idle");

    // R2 sequential read and don't-care upper address bits
    rd(16'h0000, 128, "R2");
    rd(16'hFC40, 8, "R2");
    // R3 wrap across top of array
    rd(16'h03F8, 24, "R3");

    // R6 write without enable rejected
    wr(16'h0020, 8, 50, "R6");
    rd(16'h0020, 32, "R6");

    // R4 partial write, neighbours keep contents
    op1(8'h06); wr(16'h0045, 3, 60, "R4");
    rd(16'h0040, 32, "R4");
    // R4 overflow past 32 bytes, in-page wrap, last wins
    op1(8'h06); wr(16'h0065, 40, 70, "R4");
    rd(16'h0060, 32, "R4");

    // R5 abort mid-byte: discarded, latch untouched
    op1(8'h06);
    cs_lo(); xb(8'h02, d); xb(8'h00, d); xb(8'h20, d); xb(8'hA5, d); xbits(8'hAA, 4, d); cs_hi();
    chk(busy, 0, "R5", "busy after mid-byte abort");
    stat_chk("R5");
    rd(16'h0020, 32, "R5");
    // R5 no data byte
    cs_lo(); xb(8'h02, d); xb(8'h00, d); xb(8'h20, d); cs_hi();
    chk(busy, 0, "R5", "busy without data byte");
    op1(8'h04);

    // R7 behaviour during busy
    op1(8'h06);
    cs_lo(); xb(8'h02, d); xb(8'h00, d); xb(8'h07, d); xb(8'h3C, d); cs_hi();
    em[7] = 8'h3C; ewel = 1'b0;
    rdsr(s); chk(s, 8'h01, "R7", "status during busy");
    cs_lo(); xb(8'h03, d); xb(8'h00, d); xb(8'h00, d); xb(8'h00, d);
    chk(d, 8'h00, "R7", "read during busy"); cs_hi();
    cs_lo(); xb(8'h06, d); cs_hi();
    wait_ready();
    stat_chk("R7");
    rd(16'h0000, 16, "R7");

    // R10 unknown opcode
    op1(8'h06); op1(8'hA5); stat_chk("R10");
    op1(8'h3B); stat_chk("R10");

    // R9 / R8 protection levels
    wrsr(8'h0C); stat_chk("R9");
    op1(8'h06); wr(16'h0000, 4, 80, "R8"); rd(16'h0000, 32, "R8");
    stat_chk("R8");
    wrsr(8'h04); stat_chk("R9");
    op1(8'h06); wr(16'h0300, 4, 81, "R8"); rd(16'h03E0, 32, "R8");
    wr(16'h02E0, 4, 82, "R8"); rd(16'h02E0, 8, "R8");
    op1(8'h06); wrsr(8'h08); stat_chk("R9");
    op1(8'h06); wr(16'h0200, 4, 83, "R8");
    wr(16'h01E0, 4, 84, "R8"); rd(16'h01E0, 8, "R8");
    op1(8'h06); wp = 1'b0; wrsr(8'h00); stat_chk("R9");
    wp = 1'b1; wrsr(8'h00); stat_chk("R9");
    wrsr(8'h0C); stat_chk("R9");
    chk(miso, 0, "R11", "miso idle at end");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule